// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block keeps the time of day and the calendar date in packed BCD and shows them to software as eight bytes at the very top of a 32K x 8 byte address space. A prescaler counts pulses from a 32,768 Hz reference tick, and each completed second advances a hidden counter chain (seconds, minutes, 24-hour hours, day of week, date, month, two-digit year). Month lengths and leap Februaries are handled in the chain.

Software never reads the hidden counters directly. It reads a visible copy that is refreshed from the counters in the clock cycle after each advance. Setting the freeze bit in the control byte stops that refresh, so a multi-byte read is coherent while the counters keep running. Time bytes written while frozen are staged and loaded into the counters when the freeze is released. Time bytes written while running load the counters at once. All lower addresses belong to an ordinary memory that sits outside this block. The `hit_o` output tells the surrounding logic when an address falls in the clock window.

Top module: `bcd_clock_regs`

## Requirements
- R1: `hit_o` is 1 exactly when `addr_i` is in 7FF8h..7FFFh. A read (`cs_i`=1, `we_i`=0) outside that window gives `rdata_o`=00h on the next cycle, and a write outside it changes no clock byte.
- R2: Byte offset = `addr_i[2:0]`. Offset 0 is the control byte: bit 6 is freeze, bits 5:0 are a stored calibration value, and bit 7 reads 0. Offsets 1..7 are seconds, minutes, hours, day of week, date, month, year. Written data is masked on entry to the field widths: seconds and minutes 7Fh, hours and date 3Fh, day 07h, month 1Fh, year FFh. Read data appears on `rdata_o` one cycle after the read cycle.
- R3: After reset, the bytes read control 00h, time 00:00:00, day 01h, date 01h, month 01h, year 00h.
- R4: The counters advance by one second on the tick that completes each group of `TICKS_PER_SEC` ticks counted from reset. The visible bytes take the new value one clock later, all in the same cycle. Fewer ticks change nothing.
- R5: Seconds and minutes wrap 59→00 with a carry, and hours wrap 23→00. The midnight carry advances the day of week (1..7, 7→1) and the date.
- R6: The date wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, after 30 in months 04, 06, 09 and 11, and in February after 29 when the BCD year is divisible by 4 (00 included) and after 28 otherwise. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R7: While freeze is 1, the visible time bytes hold their value and the hidden counters keep advancing.
- R8: A freeze written in the clock cycle after an advance does not cancel the pending refresh: the visible bytes still take the new second.
- R9: Writing the control byte with bit 6 = 0 while frozen refreshes the visible bytes with the current count one clock later.
- R10: A time byte written while running loads both its counter and its visible byte at once. A time byte written while frozen shows at once in the visible byte, and its counter field is loaded from it at release, replacing the value that field had counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per reference tick (32,768 per second by default) |
| cs_i | input | 1 | Access strobe for the memory port |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 15 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| hit_o | output | 1 | Address lies in the clock byte window |

## Verification
The second counter and the seconds field of the chain change on the clock edge that samples the completing tick. The visible copy changes on the following edge. Because a read is registered, a read issued in any cycle after that shows the new value, so the bench finishes each tick pulse and then starts its reads. The bench drives every input at the falling edge and samples `rdata_o` at the falling edge after the read's rising edge. The refresh race of R8 is driven cycle by cycle: the freeze write is placed in exactly the cycle between the advance and the copy. `hit_o` is combinational and is checked one time unit after the address is set.

// File: rtl/bcdclk_pkg.sv
package bcdclk_pkg;

    localparam int NFIELD     = 7;
    localparam int NREG       = NFIELD + 1;
    localparam int IDX_W      = $clog2(NREG);
    localparam int CAL_W      = 6;
    localparam int FREEZE_BIT = 6;

    // field order equals byte offset minus one
    typedef enum logic [2:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HR   = 3'd2,
        F_DOW  = 3'd3,
        F_DATE = 3'd4,
        F_MON  = 3'd5,
        F_YR   = 3'd6
    } field_e;

    // first member is most significant: vector index 0 is seconds
    typedef struct packed {
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_t;

    typedef logic [NFIELD-1:0][7:0] cal_vec_t;

    localparam cal_t CAL_RESET = '{yr: 8'h00, mon: 8'h01, date: 8'h01,
                                   dow: 8'h01, hr: 8'h00, min: 8'h00,
                                   sec: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) begin
            if (v[7:4] >= 4'd9) r = 8'h00;
            else                r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
        return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
    endfunction

    function automatic logic is_leap(input logic [7:0] yr);
        logic [7:0] b;
        b = bcd_to_bin(yr);
        return (b[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] mon,
                                              input logic [7:0] yr);
        logic [7:0] d;
        case (mon)
            8'h02:                      d = is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
            default:                    d = 8'h31;
        endcase
        return d;
    endfunction

    function automatic logic [7:0] field_mask(input logic [2:0] f);
        logic [7:0] m;
        case (field_e'(f))
            F_SEC, F_MIN:  m = 8'h7F;
            F_HR, F_DATE:  m = 8'h3F;
            F_DOW:         m = 8'h07;
            F_MON:         m = 8'h1F;
            default:       m = 8'hFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bcdclk_prescale.sv
module bcdclk_prescale #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic sec_o
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_q;

    assign sec_o = tick_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/bcdclk_chain.sv
module bcdclk_chain
    import bcdclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    input  logic [NFIELD-1:0] load_en_i,
    input  cal_t              load_val_i,
    output cal_t              cnt_o
);
    cal_t     cnt_q;
    cal_t     step;
    cal_vec_t nxt_v;
    cal_vec_t ld_v;

    always_comb begin
        step = cnt_q;
        if (adv_i) begin
            if (cnt_q.sec >= 8'h59) begin
                step.sec = 8'h00;
                if (cnt_q.min >= 8'h59) begin
                    step.min = 8'h00;
                    if (cnt_q.hr >= 8'h23) begin
                        step.hr  = 8'h00;
                        step.dow = (cnt_q.dow >= 8'h07) ? 8'h01 : bcd_inc(cnt_q.dow);
                        if (cnt_q.date >= month_days(cnt_q.mon, cnt_q.yr)) begin
                            step.date = 8'h01;
                            if (cnt_q.mon >= 8'h12) begin
                                step.mon = 8'h01;
                                step.yr  = bcd_inc(cnt_q.yr);
                            end else begin
                                step.mon = bcd_inc(cnt_q.mon);
                            end
                        end else begin
                            step.date = bcd_inc(cnt_q.date);
                        end
                    end else begin
                        step.hr = bcd_inc(cnt_q.hr);
                    end
                end else begin
                    step.min = bcd_inc(cnt_q.min);
                end
            end else begin
                step.sec = bcd_inc(cnt_q.sec);
            end
        end
    end

    assign ld_v = load_val_i;

    // per-field software load takes priority over the count
    for (genvar g = 0; g < NFIELD; g++) begin : g_fld
        cal_vec_t sv;
        assign sv       = step;
        assign nxt_v[g] = load_en_i[g] ? ld_v[g] : sv[g];
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= CAL_RESET;
        else     cnt_q <= nxt_v;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/bcdclk_shadow.sv
module bcdclk_shadow
    import bcdclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    input  cal_t              cnt_i,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [7:0]        wr_data_i,
    output cal_t              vis_o,
    output logic              freeze_o,
    output logic [CAL_W-1:0]  calib_o,
    output logic [NFIELD-1:0] load_en_o,
    output cal_t              load_val_o
);
    cal_vec_t          vis_q;
    logic              freeze_q;
    logic [CAL_W-1:0]  calib_q;
    logic [NFIELD-1:0] dirty_q;
    logic              pend_q;

    logic              ctrl_wr;
    logic              time_wr;
    logic              release_now;
    logic [2:0]        fld;
    logic [7:0]        wbyte;
    cal_vec_t          lv;
    logic [NFIELD-1:0] le;

    always_comb begin
        ctrl_wr     = wr_i && (wr_idx_i == '0);
        time_wr     = wr_i && (wr_idx_i != '0);
        fld         = 3'(wr_idx_i - IDX_W'(1));
        wbyte       = wr_data_i & field_mask(fld);
        release_now = ctrl_wr && freeze_q && !wr_data_i[FREEZE_BIT];
        lv          = vis_q;
        le          = '0;
        if (release_now) begin
            le = dirty_q;
        end else if (time_wr && !freeze_q) begin
            le[fld] = 1'b1;
            lv[fld] = wbyte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vis_q    <= CAL_RESET;
            freeze_q <= 1'b0;
            calib_q  <= '0;
            dirty_q  <= '0;
            pend_q   <= 1'b0;
        end else begin
            // freeze_q is the value before any write in this cycle, so a
            // pending copy completes even when a freeze arrives now
            if (pend_q && !freeze_q) vis_q <= cnt_i;
            pend_q <= adv_i || (pend_q && freeze_q) || release_now;
            if (ctrl_wr) begin
                freeze_q <= wr_data_i[FREEZE_BIT];
                calib_q  <= wr_data_i[CAL_W-1:0];
            end
            if (release_now) dirty_q <= '0;
            if (time_wr) begin
                vis_q[fld] <= wbyte;
                if (freeze_q) dirty_q[fld] <= 1'b1;
            end
        end
    end

    assign vis_o      = vis_q;
    assign freeze_o   = freeze_q;
    assign calib_o    = calib_q;
    assign load_en_o  = le;
    assign load_val_o = lv;
endmodule

// File: rtl/bcd_clock_regs.sv
module bcd_clock_regs
    import bcdclk_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              cs_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic              hit_o
);
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    logic              sec_pulse;
    logic              wr_en;
    logic [IDX_W-1:0]  idx;
    logic [NFIELD-1:0] load_en;
    cal_t              load_val;
    cal_t              cnt;
    cal_t              vis;
    cal_vec_t          vis_v;
    logic              freeze;
    logic [CAL_W-1:0]  calib;
    logic [7:0]        rd_byte;
    logic [7:0]        rdata_q;

    // clock window: all address bits above the byte offset are ones
    assign hit_o = &addr_i[ADDR_W-1:IDX_W];
    assign idx   = addr_i[IDX_W-1:0];
    assign wr_en = cs_i && we_i && hit_o;

    bcdclk_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .sec_o  (sec_pulse)
    );

    bcdclk_chain u_chain (
        .clk        (clk),
        .rst        (rst),
        .adv_i      (sec_pulse),
        .load_en_i  (load_en),
        .load_val_i (load_val),
        .cnt_o      (cnt)
    );

    bcdclk_shadow u_shadow (
        .clk        (clk),
        .rst        (rst),
        .adv_i      (sec_pulse),
        .cnt_i      (cnt),
        .wr_i       (wr_en),
        .wr_idx_i   (idx),
        .wr_data_i  (wdata_i),
        .vis_o      (vis),
        .freeze_o   (freeze),
        .calib_o    (calib),
        .load_en_o  (load_en),
        .load_val_o (load_val)
    );

    assign vis_v = vis;

    always_comb begin
        if (idx == '0) rd_byte = {1'b0, freeze, calib};
        else           rd_byte = vis_v[idx - ONE];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= 8'h00;
        end else if (cs_i && !we_i) begin
            rdata_q <= hit_o ? rd_byte : 8'h00;
        end
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/bcd_clock_regs_chk.sv
module bcd_clock_regs_chk
    import bcdclk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_i,
    input logic              we_i,
    input logic              hit_o,
    input logic [7:0]        rdata_o,
    input logic              sec_pulse,
    input logic              wr_en,
    input logic [IDX_W-1:0]  idx,
    input logic [NFIELD-1:0] load_en,
    input cal_t              cnt,
    input cal_t              vis,
    input logic              freeze
);
    AST_RD_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cs_i && !we_i && !hit_o) |=> (rdata_o == 8'h00)); // R1

    AST_SEC_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (sec_pulse && load_en == '0) |=> (cnt.sec != $past(cnt.sec))); // R4

    AST_COPY_AFTER_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        ($past(sec_pulse) && !freeze && !(wr_en && idx != '0)) |=> (vis == $past(cnt))); // R4

    AST_MIDNIGHT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (sec_pulse && load_en == '0 && cnt.hr == 8'h23 && cnt.min == 8'h59 && cnt.sec == 8'h59)
        |=> (cnt.hr == 8'h00 && cnt.min == 8'h00 && cnt.sec == 8'h00)); // R5

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (freeze && !wr_en) |=> $stable(vis)); // R7

    AST_FREEZE_WAITS_COPY: assert property (@(posedge clk) disable iff (rst)
        ($past(sec_pulse) && !freeze && wr_en && idx == '0) |=> (vis == $past(cnt))); // R8
endmodule

bind bcd_clock_regs bcd_clock_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_i      (cs_i),
    .we_i      (we_i),
    .hit_o     (hit_o),
    .rdata_o   (rdata_o),
    .sec_pulse (sec_pulse),
    .wr_en     (wr_en),
    .idx       (idx),
    .load_en   (load_en),
    .cnt       (cnt),
    .vis       (vis),
    .freeze    (freeze)
);

// File: tb/bcd_clock_regs_tb_top.sv
module bcd_clock_regs_tb_top;
    localparam int TPS = 4;

    typedef struct {
        int sec; int min; int hr; int dow; int date; int mon; int yr;
    } tm_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        cs = 1'b0;
    logic        we = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        hit;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    bcd_clock_regs #(.ADDR_W(15), .TICKS_PER_SEC(TPS)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .cs_i    (cs),
        .we_i    (we),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .hit_o   (hit)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) + (v % 10));
    endfunction

    function automatic int dim(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic tm_t step(input tm_t t);
        tm_t n = t;
        n.sec++;
        if (n.sec == 60) begin
            n.sec = 0; n.min++;
            if (n.min == 60) begin
                n.min = 0; n.hr++;
                if (n.hr == 24) begin
                    n.hr = 0;
                    n.dow = (n.dow == 7) ? 1 : n.dow + 1;
                    n.date++;
                    if (n.date > dim(t.mon, t.yr)) begin
                        n.date = 1; n.mon++;
                        if (n.mon == 13) begin
                            n.mon = 1;
                            n.yr = (n.yr + 1) % 100;
                        end
                    end
                end
            end
        end
        return n;
    endfunction

    function automatic tm_t mk(input int h, input int mi, input int s,
                               input int dw, input int d, input int mo, input int y);
        tm_t t;
        t.sec = s; t.min = mi; t.hr = h; t.dow = dw; t.date = d; t.mon = mo; t.yr = y;
        return t;
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk); cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk); cs = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [14:0] a, output logic [7:0] d);
        @(negedge clk); cs = 1'b1; we = 1'b0; addr = a;
        @(negedge clk); cs = 1'b0; d = rdata;
    endtask

    task automatic tick1();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic one_second();
        repeat (TPS) tick1();
        @(negedge clk);
    endtask

    task automatic set_time(input tm_t t);
        wr(15'h7FF9, bcd(t.sec));  wr(15'h7FFA, bcd(t.min));
        wr(15'h7FFB, bcd(t.hr));   wr(15'h7FFC, bcd(t.dow));
        wr(15'h7FFD, bcd(t.date)); wr(15'h7FFE, bcd(t.mon));
        wr(15'h7FFF, bcd(t.yr));
    endtask

    task automatic check_time(input tm_t t, input string req);
        logic [7:0] d;
        rd(15'h7FF9, d); chk({req, " sec"},  d, bcd(t.sec));
        rd(15'h7FFA, d); chk({req, " min"},  d, bcd(t.min));
        rd(15'h7FFB, d); chk({req, " hour"}, d, bcd(t.hr));
        rd(15'h7FFC, d); chk({req, " dow"},  d, bcd(t.dow));
        rd(15'h7FFD, d); chk({req, " date"}, d, bcd(t.date));
        rd(15'h7FFE, d); chk({req, " mon"},  d, bcd(t.mon));
        rd(15'h7FFF, d); chk({req, " year"}, d, bcd(t.yr));
    endtask

    task automatic roll_case(input tm_t t, input string req);
        set_time(t);
        one_second();
        check_time(step(t), req);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        tm_t m;
        tm_t snap;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R3 reset contents, R2 control byte layout
        rd(15'h7FF8, d); chk("R3 ctrl", d, 8'h00);
        m = mk(0, 0, 0, 1, 1, 1, 0);
        check_time(m, "R3");

        // R1 decode and outside accesses
        @(negedge clk); addr = 15'h7FF7; #1; chk("R1 hit 7FF7", {7'd0, hit}, 8'h00);
        @(negedge clk); addr = 15'h7FF8; #1; chk("R1 hit 7FF8", {7'd0, hit}, 8'h01);
        @(negedge clk); addr = 15'h7FFF; #1; chk("R1 hit 7FFF", {7'd0, hit}, 8'h01);
        rd(15'h7FFC, d);
        rd(15'h1234, d); chk("R1 outside read", d, 8'h00);
        wr(15'h7FF1, 8'h55);
        wr(15'h0009, 8'h33);
        check_time(m, "R1 outside write");

        // R4 partial second then completion
        repeat (TPS - 1) tick1();
        rd(15'h7FF9, d); chk("R4 partial", d, 8'h00);
        tick1();
        rd(15'h7FF9, d); chk("R4 full", d, 8'h01);
        m = step(m);

        // R2 control byte and masks
        wr(15'h7FF8, 8'h15); rd(15'h7FF8, d); chk("R2 calib", d, 8'h15);
        wr(15'h7FF8, 8'hC0); rd(15'h7FF8, d); chk("R2 bit7 reads 0", d, 8'h40);
        wr(15'h7FF8, 8'h00);
        wr(15'h7FFB, 8'hFF); rd(15'h7FFB, d); chk("R2 hour mask", d, 8'h3F);
        wr(15'h7FFC, 8'hFF); rd(15'h7FFC, d); chk("R2 dow mask", d, 8'h07);
        wr(15'h7FF9, 8'hFF); rd(15'h7FF9, d); chk("R2 sec mask", d, 8'h7F);

        // R5 / R6 directed rollovers
        roll_case(mk(10, 14, 59, 3, 5, 6, 42), "R5 minute carry");
        roll_case(mk(9, 59, 59, 3, 5, 6, 42), "R5 hour carry");
        roll_case(mk(23, 59, 59, 7, 12, 6, 42), "R5 midnight dow wrap");
        roll_case(mk(23, 59, 59, 2, 28, 2, 23), "R6 feb common");
        roll_case(mk(23, 59, 59, 2, 28, 2, 24), "R6 feb leap 28");
        roll_case(mk(23, 59, 59, 2, 29, 2, 0), "R6 feb leap year 00");
        roll_case(mk(23, 59, 59, 4, 30, 4, 11), "R6 30-day month");
        roll_case(mk(23, 59, 59, 4, 30, 5, 11), "R6 31-day month mid");
        roll_case(mk(23, 59, 59, 5, 31, 12, 99), "R6 year 99 wrap");

        // R5 / R6 constrained random
        for (int i = 0; i < 24; i++) begin
            tm_t t;
            int n;
            t.mon = 1 + int'($urandom % 12);
            t.yr = int'($urandom % 100);
            t.date = ($urandom % 2 == 0) ? dim(t.mon, t.yr) : 1 + int'($urandom % dim(t.mon, t.yr));
            t.dow = 1 + int'($urandom % 7);
            if ($urandom % 2 == 0) begin
                t.hr = 23; t.min = 59; t.sec = 58 + int'($urandom % 2);
            end else begin
                t.hr = int'($urandom % 24); t.min = int'($urandom % 60); t.sec = int'($urandom % 60);
            end
            set_time(t);
            n = 1 + int'($urandom % 3);
            for (int k = 0; k < n; k++) begin
                one_second();
                t = step(t);
            end
            check_time(t, "R6 random");
        end

        // R7 freeze holds view, counters run; R9 release refreshes
        m = mk(8, 30, 57, 2, 14, 3, 50);
        set_time(m);
        wr(15'h7FF8, 8'h40);
        snap = m;
        for (int k = 0; k < 3; k++) begin
            one_second();
            m = step(m);
        end
        check_time(snap, "R7 frozen");
        wr(15'h7FF8, 8'h00);
        check_time(m, "R9 release");

        // R10 time write while running
        wr(15'h7FFA, 8'h45); rd(15'h7FFA, d); chk("R10 running write", d, 8'h45);
        m.min = 45;
        one_second(); m = step(m);
        check_time(m, "R10 running load");

        // R10 time write while frozen, loaded at release
        m = mk(10, 20, 5, 6, 9, 9, 9);
        set_time(m);
        wr(15'h7FF8, 8'h40);
        wr(15'h7FF9, 8'h30); rd(15'h7FF9, d); chk("R10 frozen visible", d, 8'h30);
        rd(15'h7FFA, d); chk("R10 frozen other byte", d, 8'h20);
        one_second(); m = step(m);
        wr(15'h7FF8, 8'h00);
        m.sec = 30;
        check_time(m, "R10 frozen load");
        one_second(); m = step(m);
        rd(15'h7FF9, d); chk("R10 after load advance", d, 8'h31);

        // R8 freeze arriving right after an advance keeps that refresh
        repeat (TPS - 1) tick1();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        cs = 1'b1; we = 1'b1; addr = 15'h7FF8; wdata = 8'h40;
        @(negedge clk); cs = 1'b0; we = 1'b0;
        m = step(m);
        rd(15'h7FF9, d); chk("R8 pending refresh kept", d, bcd(m.sec));
        one_second(); m = step(m);
        rd(15'h7FF9, d); chk("R8 then frozen", d, 8'h32);
        wr(15'h7FF8, 8'h00);
        check_time(m, "R9 release after R8");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule